// File: doc/BRIEF.md
# Synchronous Burst ROM Read Controller

This block is the read-side controller of a single-bank read-only memory with a command interface in the style of synchronous DRAM. Every input is sampled on the rising clock edge. A strobe decoder turns chip select, row strobe, column strobe and mode strobe into commands. An activate command latches a row from the shared address bus, and a read command latches a column and the data width. After the programmed CAS latency, the block streams a burst of 4 or 8 words, in sequential or interleaved column order. No precharge, refresh or start-up sequence is needed. Precharge only ends the running burst.

The memory contents come from a computed behavioural array. The output is a plain data bus with one drive enable per 16-bit lane, and a lane whose enable is low is treated as high-Z. The data stream has no ready input. The slots are fixed by the latency, and the only way to hold the stream back is the clock-enable input, which freezes the whole controller, outputs included.

Top module: `sbrom_ctrl`

## Requirements
- R1: After reset the mode register holds CAS latency 5, sequential order and burst length 4, `dq_oe` is 00 and `dq_out` is 0. An activate is accepted as the first command.
- R2: With `cs_n` low, {`ras_n`,`cas_n`,`mrs_n`} decodes as follows: 000 mode set, 011 activate, 101 read, 110 burst stop, 010 precharge, and any other pattern is no operation. With `cs_n` high every strobe pattern is ignored.
- R3: The mode set key uses `addr[5:3]` for latency (100 gives 4, 101 gives 5), `addr[2]` for order (0 sequential, 1 interleaved) and `addr[1:0]` for length (01 gives 4, 10 gives 8). A key with a reserved latency or length code, or with `addr[8:7]` not 00, leaves the register unchanged.
- R4: Any command in the 3 enabled cycles after an accepted mode set is ignored.
- R5: Activate latches `addr[12:0]` as the row, and the row holds until the next activate. Read latches the column (`addr[7:0]` for 16-bit, `addr[6:0]` for 32-bit) and samples `wide` (1 selects 32-bit, 0 selects 16-bit).
- R6: Word contents: word(w) = {w[7:0],w[15:8]} ^ {11'b0,w[20:16]} for a 21-bit word address w. In 16-bit mode w={row,col}, the word appears on `dq_out[15:0]` and `dq_oe`=01. In 32-bit mode, with d={row,col7}, `dq_out[15:0]`=word({d,0}), `dq_out[31:16]`=word({d,1}) and `dq_oe`=11. A lane whose enable is low drives 0.
- R7: For a read sampled at enabled edge k, beat 0 is seen at enabled edge k+CL. The burst runs for BL consecutive beats, and `dq_oe` then returns to 00 unless a later read's burst starts.
- R8: The column of beat i is start^i in interleaved order, or (start+i) mod BL in the low bits in sequential order. The upper column bits stay fixed in both orders.
- R9: A read or activate issued CL-1 or more enabled cycles after a read does not cancel it. The earlier burst runs until the new burst's beat 0 replaces it, with no gap.
- R10: A read or activate issued fewer than CL-1 enabled cycles after a read cancels that read, and none of its beats appear.
- R11: Burst stop and precharge sampled at enabled edge k force `dq_oe` to 00 from edge k+CL. The rest of that burst is dropped.
- R12: `dqm` sampled high at edge k masks the beat seen at edge k+2 (`dq_oe`=00, `dq_out`=0). The burst still advances.
- R13: `cke` sampled low at edge k makes edge k+1 a non-edge for the controller. State and outputs hold and every other input is ignored. In idle this is power down, which keeps the mode and the row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable for the following edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| mrs_n | input | 1 | Mode strobe, active low |
| dqm | input | 1 | Output mask, applied two edges later |
| wide | input | 1 | Width select sampled with read: 1 = 32-bit |
| addr | input | 13 | Multiplexed row / column / mode key |
| dq_out | output | 32 | Read data, two 16-bit lanes |
| dq_oe | output | 2 | Per-lane drive enable (0 = high-Z) |

## Verification
The embedded properties assume that `rst_n` is low before the first rising edge and that every input is at a known level at each edge. The lockout and stop properties also assume that stop and read countdowns never land on the same edge. The stimulus changes inputs only on falling edges and uses only the encoded command patterns. After a stop, a new read is issued only once the stop's latency has run out, so no launch meets a stop. Reserved mode keys are sent on purpose, with the lockout respected after each one, so the only things that change are the keys.

// File: rtl/sbrom_pkg.sv
`timescale 1ns/1ps
package sbrom_pkg;
  typedef enum logic [2:0] {
    C_NOP, C_MRS, C_ACT, C_READ, C_STOP, C_PRE
  } cmd_e;

  typedef struct packed {
    logic [2:0] cl;    // latency in cycles, 4 or 5
    logic       ilv;   // 1 = interleaved order
    logic       bl8;   // 1 = burst of 8, 0 = burst of 4
  } mode_t;

  localparam mode_t MODE_AT_RESET = '{cl: 3'd5, ilv: 1'b0, bl8: 1'b0};
endpackage

// File: rtl/sbrom_cmd_dec.sv
`timescale 1ns/1ps
module sbrom_cmd_dec import sbrom_pkg::*; #(
  parameter int GAP = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       mrs_n,
  input  logic [7:0] key,    // {addr[8:7], addr[5:0]}
  output cmd_e       cmd,
  output mode_t      mode
);
  localparam int LW = $clog2(GAP + 1);

  logic [LW-1:0] lock_q;
  cmd_e          raw;
  logic          key_ok;

  always_comb begin
    raw = C_NOP;
    if (!cs_n) begin
      case ({ras_n, cas_n, mrs_n})
        3'b000:  raw = C_MRS;
        3'b011:  raw = C_ACT;
        3'b101:  raw = C_READ;
        3'b110:  raw = C_STOP;
        3'b010:  raw = C_PRE;
        default: raw = C_NOP;
      endcase
    end
  end

  assign cmd = (en && lock_q == '0) ? raw : C_NOP;

  assign key_ok = (key[7:6] == 2'b00) &&
                  (key[5:3] == 3'b100 || key[5:3] == 3'b101) &&
                  (key[1:0] == 2'b01 || key[1:0] == 2'b10);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
      mode   <= MODE_AT_RESET;
    end else if (en) begin
      if (cmd == C_MRS) lock_q <= LW'(GAP);
      else if (lock_q != '0) lock_q <= lock_q - 1'b1;
      if (cmd == C_MRS && key_ok)
        mode <= '{cl: (key[3] ? 3'd5 : 3'd4), ilv: key[2], bl8: key[1]};
    end
  end

  // R4: the edge after an accepted mode set accepts nothing
  p_lock_after_mrs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_MRS) |=> (cmd == C_NOP));

  // R3: the register only ever holds legal settings
  p_mode_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode.cl == 3'd4 || mode.cl == 3'd5));
endmodule

// File: rtl/sbrom_burst_ord.sv
`timescale 1ns/1ps
module sbrom_burst_ord #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] start,
  input  logic [2:0]       beat,
  input  logic             ilv,
  input  logic             bl8,
  output logic [COL_W-1:0] col
);
  logic [2:0] low;

  assign low = ilv ? (start[2:0] ^ beat) : (start[2:0] + beat);

  always_comb begin
    col = start;
    if (bl8) col[2:0] = low;
    else     col[1:0] = low[1:0];
  end
endmodule

// File: rtl/sbrom_word.sv
`timescale 1ns/1ps
module sbrom_word #(
  parameter int AW = 21,
  parameter int DW = 16
) (
  input  logic [AW-1:0] waddr,
  output logic [DW-1:0] data
);
  localparam int HI_W = AW - 16;

  logic [HI_W-1:0] hi;

  assign hi   = waddr[AW-1:16];
  assign data = DW'({waddr[7:0], waddr[15:8]}) ^ DW'(hi);
endmodule

// File: rtl/sbrom_ctrl.sv
`timescale 1ns/1ps
module sbrom_ctrl import sbrom_pkg::*; #(
  parameter int ROW_W   = 13,
  parameter int COL_W   = 8,
  parameter int LANE_W  = 16,
  parameter int MRS_GAP = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cke,
  input  logic                cs_n,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                mrs_n,
  input  logic                dqm,
  input  logic                wide,
  input  logic [ROW_W-1:0]    addr,
  output logic [2*LANE_W-1:0] dq_out,
  output logic [1:0]          dq_oe
);
  localparam int WA_W = ROW_W + COL_W;

  // internal clock enable, sampled one edge ahead
  logic cke_q, en;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b1;
    else        cke_q <= cke;
  end
  assign en = cke_q;

  cmd_e  cmd;
  mode_t mode;

  sbrom_cmd_dec #(.GAP(MRS_GAP)) u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .mrs_n (mrs_n),
    .key   ({addr[8:7], addr[5:0]}),
    .cmd   (cmd),
    .mode  (mode)
  );

  // latched row, pending read, stop countdown, running burst
  logic [ROW_W-1:0] row_q;
  logic             p_v, p_wide, p_ilv, p_bl8;
  logic [2:0]       p_cnt;
  logic [ROW_W-1:0] p_row;
  logic [COL_W-1:0] p_col;
  logic             s_v;
  logic [2:0]       s_cnt;
  logic             b_v, b_wide, b_ilv, b_bl8;
  logic [2:0]       b_beat;
  logic [ROW_W-1:0] b_row;
  logic [COL_W-1:0] b_col;
  logic             dqm_q;

  logic             launch, stop_fire, b_last, show;
  logic [COL_W-1:0] col_in;

  assign launch    = en && p_v && (p_cnt == 3'd1);
  assign stop_fire = en && s_v && (s_cnt == 3'd1);
  assign b_last    = (b_beat == (b_bl8 ? 3'd7 : 3'd3));
  assign show      = launch || (b_v && !b_last && !stop_fire);
  assign col_in    = wide ? {1'b0, addr[COL_W-2:0]} : addr[COL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      p_v    <= 1'b0;
      p_cnt  <= '0;
      p_row  <= '0;
      p_col  <= '0;
      p_wide <= 1'b0;
      p_ilv  <= 1'b0;
      p_bl8  <= 1'b0;
      s_v    <= 1'b0;
      s_cnt  <= '0;
      b_v    <= 1'b0;
      b_beat <= '0;
      b_row  <= '0;
      b_col  <= '0;
      b_wide <= 1'b0;
      b_ilv  <= 1'b0;
      b_bl8  <= 1'b0;
      dqm_q  <= 1'b0;
    end else if (en) begin
      dqm_q <= dqm;
      if (cmd == C_ACT) row_q <= addr;

      // pending read: a new read replaces it, activate cancels it
      if (cmd == C_READ) begin
        p_v    <= 1'b1;
        p_cnt  <= mode.cl - 3'd1;
        p_row  <= row_q;
        p_col  <= col_in;
        p_wide <= wide;
        p_ilv  <= mode.ilv;
        p_bl8  <= mode.bl8;
      end else if (launch || cmd == C_ACT) begin
        p_v <= 1'b0;
      end else if (p_v) begin
        p_cnt <= p_cnt - 3'd1;
      end

      // stop / precharge countdown
      if (cmd == C_STOP || cmd == C_PRE) begin
        s_v   <= 1'b1;
        s_cnt <= mode.cl - 3'd1;
      end else if (stop_fire) begin
        s_v <= 1'b0;
      end else if (s_v) begin
        s_cnt <= s_cnt - 3'd1;
      end

      // running burst
      if (launch) begin
        b_v    <= 1'b1;
        b_beat <= 3'd0;
        b_row  <= p_row;
        b_col  <= p_col;
        b_wide <= p_wide;
        b_ilv  <= p_ilv;
        b_bl8  <= p_bl8;
      end else if (stop_fire) begin
        b_v <= 1'b0;
      end else if (b_v) begin
        if (b_last) b_v <= 1'b0;
        else        b_beat <= b_beat + 3'd1;
      end
    end
  end

  // address of the beat about to be shown
  logic [COL_W-1:0] o_start, o_col;
  logic [2:0]       o_beat;
  logic             o_ilv, o_bl8, o_wide;
  logic [ROW_W-1:0] o_row;

  always_comb begin
    if (launch) begin
      o_start = p_col;
      o_beat  = 3'd0;
      o_ilv   = p_ilv;
      o_bl8   = p_bl8;
      o_wide  = p_wide;
      o_row   = p_row;
    end else begin
      o_start = b_col;
      o_beat  = b_beat + 3'd1;
      o_ilv   = b_ilv;
      o_bl8   = b_bl8;
      o_wide  = b_wide;
      o_row   = b_row;
    end
  end

  sbrom_burst_ord #(.COL_W(COL_W)) u_ord (
    .start (o_start),
    .beat  (o_beat),
    .ilv   (o_ilv),
    .bl8   (o_bl8),
    .col   (o_col)
  );

  logic [2*LANE_W-1:0] rd_data;
  logic [1:0]          lane_en;

  assign lane_en = o_wide ? 2'b11 : 2'b01;

  for (genvar l = 0; l < 2; l++) begin : g_lane
    localparam logic LB = (l == 1);
    logic [WA_W-1:0] wa;
    assign wa = o_wide ? {o_row, o_col[COL_W-2:0], LB} : {o_row, o_col};
    sbrom_word #(.AW(WA_W), .DW(LANE_W)) u_word (
      .waddr (wa),
      .data  (rd_data[l*LANE_W +: LANE_W])
    );
  end

  logic [2*LANE_W-1:0] dq_q;
  logic [1:0]          oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_q <= '0;
      oe_q <= 2'b00;
    end else if (en) begin
      if (show && !dqm_q) begin
        oe_q <= lane_en;
        dq_q <= {(lane_en[1] ? rd_data[2*LANE_W-1:LANE_W] : {LANE_W{1'b0}}),
                 rd_data[LANE_W-1:0]};
      end else begin
        oe_q <= 2'b00;
        dq_q <= '0;
      end
    end
  end

  assign dq_out = dq_q;
  assign dq_oe  = oe_q;

  // R13: a suppressed edge leaves the outputs untouched
  p_freeze_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_q |=> ($stable(dq_out) && $stable(dq_oe)));

  // R12: a sampled mask blanks the next loaded beat
  p_mask_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dqm_q) |=> (dq_oe == 2'b00));

  // R11: a firing stop with no new burst empties the bus
  p_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_fire && !launch) |=> (dq_oe == 2'b00));

  // R7: a launch with no mask puts beat 0 on the lower lane
  p_launch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !dqm_q) |=> dq_oe[0]);

  // R10: an early activate drops the pending read
  p_cancel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && p_v && p_cnt > 3'd1 && cmd == C_ACT) |=> !p_v);

  // R6: lane enables are 00, 01 or 11, and idle lanes carry zero
  p_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe != 2'b10) && (dq_oe[1] || dq_out[2*LANE_W-1:LANE_W] == '0) &&
    (dq_oe[0] || dq_out[LANE_W-1:0] == '0));
endmodule

// File: tb/sbrom_ctrl_test.sv
`timescale 1ns/1ps
module sbrom_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, mrs_n = 1'b1;
  logic        dqm = 1'b0, wide = 1'b0;
  logic [12:0] addr = '0;
  logic [31:0] dq_out;
  logic [1:0]  dq_oe;

  localparam logic [2:0] K_MRS = 3'b000, K_ACT = 3'b011, K_RD = 3'b101,
                         K_STOP = 3'b110, K_PRE = 3'b010, K_NOP = 3'b111;

  int nchk = 0, nerr = 0;
  logic [12:0] row_cur;

  always #4 clk = ~clk;

  sbrom_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .mrs_n(mrs_n), .dqm(dqm), .wide(wide), .addr(addr),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic wrap_up;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    wrap_up();
  end

  // one cycle of stimulus, ending at the next falling edge
  task automatic tick(input logic cs, input logic [2:0] rcm, input logic [12:0] a,
                      input logic w, input logic m, input logic k);
    cs_n = cs; {ras_n, cas_n, mrs_n} = rcm; addr = a; wide = w; dqm = m; cke = k;
    @(negedge clk);
  endtask

  task automatic cmd(input logic [2:0] rcm, input logic [12:0] a, input logic w);
    tick(1'b0, rcm, a, w, 1'b0, 1'b1);
  endtask

  task automatic nop(input int n);
    repeat (n) tick(1'b1, K_NOP, 13'h0, 1'b0, 1'b0, 1'b1);
  endtask

  function automatic logic [15:0] wordf(input logic [20:0] w);
    return {w[7:0], w[15:8]} ^ {11'd0, w[20:16]};
  endfunction

  function automatic logic [7:0] colf(input logic [7:0] s, input int i,
                                      input logic bl8, input logic ilv);
    logic [2:0] o;
    o = ilv ? (s[2:0] ^ 3'(i)) : (s[2:0] + 3'(i));
    colf = s;
    if (bl8) colf[2:0] = o;
    else     colf[1:0] = o[1:0];
  endfunction

  task automatic chk(input string tag, input logic [1:0] eo, input logic [31:0] ed);
    nchk++;
    if (dq_oe !== eo || dq_out !== ed) begin
      nerr++;
      $display("FAIL %s: got oe=%b dq=%h expected oe=%b dq=%h", tag, dq_oe, dq_out, eo, ed);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(tag, 2'b00, 32'h0);
  endtask

  task automatic expect_beat(input string tag, input logic [12:0] r,
                             input logic [7:0] c, input logic w);
    logic [31:0] e;
    logic [1:0]  eo;
    if (w) begin
      e  = {wordf({r, c[6:0], 1'b1}), wordf({r, c[6:0], 1'b0})};
      eo = 2'b11;
    end else begin
      e  = {16'h0, wordf({r, c})};
      eo = 2'b01;
    end
    chk(tag, eo, e);
  endtask

  task automatic expect_burst(input string tag, input logic [12:0] r, input logic [7:0] s,
                              input logic w, input logic bl8, input logic ilv,
                              input int first, input int last);
    for (int i = first; i <= last; i++) begin
      expect_beat(tag, r, colf(s, i, bl8, ilv), w);
      nop(1);
    end
  endtask

  task automatic t_reset;
    chk_idle("R1 reset outputs");
  endtask

  task automatic t_default;
    cmd(K_ACT, 13'h0A5, 1'b0);
    row_cur = 13'h0A5;
    tick(1'b1, K_ACT, 13'h055, 1'b0, 1'b0, 1'b1);   // R2: deselected, ignored
    cmd(K_RD, 13'h012, 1'b0);
    nop(3);
    chk_idle("R1 no data before latency 5");
    nop(1);
    expect_burst("R1 R2 R5 R7 R8 default seq bl4", row_cur, 8'h12, 1'b0, 1'b0, 1'b0, 0, 3);
    chk_idle("R7 bus idle after burst");
  endtask

  task automatic t_mode_lock;
    cmd(K_MRS, 13'h026, 1'b0);                      // CL4, interleaved, BL8
    cmd(K_ACT, 13'h111, 1'b0);                      // R4: locked out
    nop(2);
    cmd(K_RD, 13'h005, 1'b1);
    nop(3);
    expect_burst("R3 R4 R6 R8 x32 ilv bl8", row_cur, 8'h05, 1'b1, 1'b1, 1'b1, 0, 7);
    chk_idle("R7 idle after bl8");
  endtask

  task automatic t_reserved;
    cmd(K_MRS, 13'h032, 1'b0);                      // reserved latency code
    nop(3);
    cmd(K_MRS, 13'h0A9, 1'b0);                      // addr[7] set
    nop(3);
    cmd(K_RD, 13'h041, 1'b0);
    nop(2);
    chk_idle("R3 before latency 4");
    nop(1);
    expect_burst("R3 reserved keys kept CL4 ilv bl8", row_cur, 8'h41, 1'b0, 1'b1, 1'b1, 0, 7);
  endtask

  task automatic t_gapless;
    cmd(K_RD, 13'h010, 1'b0);
    nop(2);
    cmd(K_RD, 13'h0C3, 1'b0);
    expect_burst("R9 first burst until handover", row_cur, 8'h10, 1'b0, 1'b1, 1'b1, 0, 2);
    expect_burst("R9 second burst gapless", row_cur, 8'hC3, 1'b0, 1'b1, 1'b1, 0, 7);
    chk_idle("R9 idle after second burst");
  endtask

  task automatic t_preempt;
    cmd(K_RD, 13'h020, 1'b0);
    cmd(K_RD, 13'h0E6, 1'b0);
    nop(2);
    chk_idle("R10 cancelled read shows nothing");
    nop(1);
    expect_burst("R10 replacing read", row_cur, 8'hE6, 1'b0, 1'b1, 1'b1, 0, 7);
    cmd(K_RD, 13'h030, 1'b0);
    nop(1);
    cmd(K_ACT, 13'h1F0, 1'b0);
    row_cur = 13'h1F0;
    for (int i = 0; i < 4; i++) begin
      nop(1);
      chk_idle("R10 read cancelled by activate");
    end
  endtask

  task automatic t_stop;
    cmd(K_RD, 13'h044, 1'b0);
    nop(1);
    cmd(K_STOP, 13'h0, 1'b0);
    nop(1);
    expect_burst("R11 beats before stop", row_cur, 8'h44, 1'b0, 1'b1, 1'b1, 0, 1);
    chk_idle("R11 stop ends burst");
    nop(1);
    chk_idle("R11 stop stays idle");
    nop(3);
    cmd(K_RD, 13'h08B, 1'b0);
    nop(2);
    cmd(K_PRE, 13'h0, 1'b0);
    expect_burst("R11 beats before precharge", row_cur, 8'h8B, 1'b0, 1'b1, 1'b1, 0, 2);
    chk_idle("R11 precharge ends burst");
    nop(1);
    chk_idle("R11 precharge stays idle");
    nop(3);
  endtask

  task automatic t_mask;
    cmd(K_RD, 13'h0D2, 1'b0);
    nop(3);
    expect_beat("R12 beat0 unmasked", row_cur, colf(8'hD2, 0, 1'b1, 1'b1), 1'b0);
    tick(1'b1, K_NOP, 13'h0, 1'b0, 1'b1, 1'b1);
    expect_beat("R12 beat1 unmasked", row_cur, colf(8'hD2, 1, 1'b1, 1'b1), 1'b0);
    nop(1);
    chk_idle("R12 beat2 masked");
    nop(1);
    expect_burst("R12 burst continues", row_cur, 8'hD2, 1'b0, 1'b1, 1'b1, 3, 7);
    chk_idle("R12 idle after burst");
  endtask

  task automatic t_cke;
    cmd(K_RD, 13'h07F, 1'b1);
    nop(3);
    expect_beat("R13 beat0", row_cur, colf(8'h7F, 0, 1'b1, 1'b1), 1'b1);
    tick(1'b1, K_NOP, 13'h0, 1'b0, 1'b0, 1'b0);
    expect_beat("R13 beat1", row_cur, colf(8'h7F, 1, 1'b1, 1'b1), 1'b1);
    nop(1);
    expect_beat("R13 beat1 held by suspend", row_cur, colf(8'h7F, 1, 1'b1, 1'b1), 1'b1);
    nop(1);
    expect_burst("R13 burst resumes", row_cur, 8'h7F, 1'b1, 1'b1, 1'b1, 2, 7);
    chk_idle("R13 idle after suspended burst");
    tick(1'b1, K_NOP, 13'h0, 1'b0, 1'b0, 1'b0);
    tick(1'b0, K_ACT, 13'h0FF, 1'b0, 1'b0, 1'b0);
    chk_idle("R13 power down idle");
    tick(1'b0, K_ACT, 13'h0EE, 1'b0, 1'b0, 1'b1);
    cmd(K_RD, 13'h019, 1'b0);
    nop(3);
    expect_burst("R13 row and mode kept over power down", row_cur, 8'h19, 1'b0, 1'b1, 1'b1, 0, 7);
  endtask

  task automatic t_seq8;
    cmd(K_MRS, 13'h02A, 1'b0);                      // CL5, sequential, BL8
    nop(3);
    cmd(K_RD, 13'h03D, 1'b0);
    nop(4);
    expect_burst("R8 sequential bl8 wrap x16", row_cur, 8'h3D, 1'b0, 1'b1, 1'b0, 0, 7);
    cmd(K_RD, 13'h07E, 1'b1);
    nop(4);
    expect_burst("R8 sequential bl8 wrap x32", row_cur, 8'h7E, 1'b1, 1'b1, 1'b0, 0, 7);
    chk_idle("R7 idle at end");
  endtask

  initial begin
    row_cur = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default();
    t_mode_lock();
    t_reserved();
    t_gapless();
    t_preempt();
    t_stop();
    t_mask();
    t_cke();
    t_seq8();
    wrap_up();
  end
endmodule